// File: doc/BRIEF.md
# Parity-Aligned Three-Lane Frame Receiver

This block takes three serial data lanes, all sampled on one recovered bit clock, and rebuilds a stream of four 8-bit samples (A, B, C and D) that a sender spreads over the lanes in a fixed 12-slot frame. The stream has no sync word, marker or gap. The receiver finds the frame boundary only from the odd parity that every word carries. It keeps the last 12 bits of each lane, and each cycle it treats the newest bit as a possible frame end. It unpacks the four words and their parity bits from that window and tests all four.

Each of the 12 possible offsets has its own run counter. Lock is declared after a set number of consecutive frames pass at one offset. After that, one frame is emitted every 12 cycles, with a one-cycle valid strobe, the four bytes and one parity-error flag per word. A run of failed frames at the locked offset drops lock, and the search starts again from nothing. Clock recovery, line receivers and any host bridge sit outside this block.

Top module: `rx3_frame_rx`

## Requirements
- R1: Frame layout, slot 0 being the first bit of a frame. In slots 0 to 7, lane 0 carries A, lane 1 carries B and lane 2 carries C, least significant bit first. In slot 8 the three lanes carry the parity bits of A, B and C. In slots 9, 10 and 11, lane 0 carries D bits 0, 1, 2, lane 1 carries D bits 3, 4, 5, and lane 2 carries D bit 6, D bit 7 and D's parity bit.
- R2: A word passes when it and its parity bit together hold an odd number of ones. `par_err_o` bit 0 flags A, bit 1 flags B, bit 2 flags C and bit 3 flags D; a bit is 1 when that word fails.
- R3: While unlocked, the candidate frame ending at the newest bit is checked on every cycle. `lock_o` rises one clock edge after the edge that samples the last bit of the 4th consecutive frame at one offset in which all four words pass.
- R4: `frame_vld_o` is high for exactly one cycle per frame, and only for frames that complete while lock is held. It is high one edge after the edge that samples the frame's last bit, so strobes are 12 cycles apart.
- R5: On a strobe, the word outputs carry A to D of that frame. Between strobes, the word and error outputs hold their values.
- R6: A frame that completes while locked and has any parity error is still emitted. After 3 consecutive such frames, `lock_o` falls on the same edge that emits the third one. A fully passing frame resets that run.
- R7: When lock is lost, all pass history is discarded. Locking again, at any offset, needs 4 new consecutive passing frames.
- R8: Reset clears lock, all pass and fail runs, the lane shift registers and the outputs. The first windows after reset therefore hold zeros in the slots not yet filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_i | input | 3 | One bit per lane per cycle, bit n = lane n |
| frame_vld_o | output | 1 | One-cycle strobe per emitted frame |
| word_a_o | output | 8 | Sample A |
| word_b_o | output | 8 | Sample B |
| word_c_o | output | 8 | Sample C |
| word_d_o | output | 8 | Sample D |
| par_err_o | output | 4 | Per-word parity failure, bit 0 = A ... bit 3 = D |
| lock_o | output | 1 | Frame alignment held |

## Verification
The bench builds the receiver with 4 passing frames to lock and 3 failing frames to unlock, so it can reach both thresholds and the counts just short of them within a few dozen frames. It starts the stream at two different bit offsets, with a run of zeros between them, so that the second lock has to be found from a fresh search at a new offset. Its reference model decides lock from a history of per-cycle parity results, taken at a stride of 12, and not from counters. It also covers single, double and all-word parity faults, failing runs broken by a passing frame, and a reset in the middle of the stream.

// File: rtl/rx3_pkg.sv
package rx3_pkg;
  localparam int LANES    = 3;
  localparam int SLOTS    = 12;
  localparam int WORD_W   = 8;
  localparam int WORDS    = 4;
  localparam int PAR_SLOT = WORD_W;
  localparam int TAIL     = SLOTS - PAR_SLOT - 1;

  typedef logic [LANES-1:0][SLOTS-1:0]  window_t;
  typedef logic [WORDS-1:0][WORD_W-1:0] word_set_t;
endpackage

// File: rtl/rx3_lane_shift.sv
module rx3_lane_shift
  import rx3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] ser_i,
  output window_t          win_o
);
  window_t win_q, win_d;

  // newest bit enters the top slot, oldest leaves slot 0
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      win_d[l] = {ser_i[l], win_q[l][SLOTS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win_o = win_q;
endmodule

// File: rtl/rx3_frame_decode.sv
module rx3_frame_decode
  import rx3_pkg::*;
(
  input  window_t          win_i,
  output word_set_t        words_o,
  output logic [WORDS-1:0] perr_o,
  output logic             all_ok_o
);
  logic [WORDS-1:0] par_bit;

  genvar l, t, w;
  // the first three words each sit whole on one lane
  for (l = 0; l < LANES; l++) begin : g_lane_word
    assign words_o[l] = win_i[l][WORD_W-1:0];
    assign par_bit[l] = win_i[l][PAR_SLOT];
  end

  // the last word is spread over the tail slots of all lanes
  for (l = 0; l < LANES; l++) begin : g_tail_lane
    for (t = 0; t < TAIL; t++) begin : g_tail_slot
      localparam int IDX = l * TAIL + t;
      if (IDX < WORD_W) begin : g_data
        assign words_o[WORDS-1][IDX] = win_i[l][PAR_SLOT+1+t];
      end else begin : g_par
        assign par_bit[WORDS-1] = win_i[l][PAR_SLOT+1+t];
      end
    end
  end

  // odd parity: word plus parity bit must hold an odd count of ones
  for (w = 0; w < WORDS; w++) begin : g_check
    assign perr_o[w] = ~^{par_bit[w], words_o[w]};
  end

  assign all_ok_o = ~|perr_o;
endmodule

// File: rtl/rx3_align_ctrl.sv
module rx3_align_ctrl
  import rx3_pkg::*;
#(
  parameter int LOCK_FRAMES   = 4,
  parameter int UNLOCK_FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_ok_i,
  output logic locked_o,
  output logic frame_tick_o
);
  localparam int PH_W   = $clog2(SLOTS);
  localparam int PASS_W = $clog2(LOCK_FRAMES + 1);
  localparam int FAIL_W = $clog2(UNLOCK_FRAMES + 1);
  localparam logic [PH_W-1:0]   LAST_PH  = PH_W'(SLOTS - 1);
  localparam logic [PASS_W-1:0] PASS_TOP = PASS_W'(LOCK_FRAMES - 1);
  localparam logic [FAIL_W-1:0] FAIL_TOP = FAIL_W'(UNLOCK_FRAMES - 1);

  logic [PH_W-1:0]   phase_q, phase_d;
  logic [PH_W-1:0]   lockph_q, lockph_d;
  logic              locked_q, locked_d;
  logic [FAIL_W-1:0] fail_q, fail_d;
  logic [PASS_W-1:0] pass_q [SLOTS];
  logic [PASS_W-1:0] pass_d [SLOTS];
  logic              tick, acquire, drop, lockph_en;

  always_comb begin
    phase_d   = (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
    tick      = locked_q && (phase_q == lockph_q);
    acquire   = !locked_q && all_ok_i && (pass_q[phase_q] == PASS_TOP);
    drop      = tick && !all_ok_i && (fail_q == FAIL_TOP);
    lockph_en = acquire;
    lockph_d  = phase_q;
    locked_d  = locked_q;
    fail_d    = fail_q;
    if (acquire) begin
      locked_d = 1'b1;
      fail_d   = '0;
    end else if (tick) begin
      if (all_ok_i) begin
        fail_d = '0;
      end else if (drop) begin
        locked_d = 1'b0;
        fail_d   = '0;
      end else begin
        fail_d = fail_q + 1'b1;
      end
    end
  end

  // one pass-run counter per candidate offset; idle while locked
  always_comb begin
    for (int o = 0; o < SLOTS; o++) begin
      if (locked_q || acquire)        pass_d[o] = '0;
      else if (phase_q == PH_W'(o))   pass_d[o] = all_ok_i ? pass_q[o] + 1'b1 : '0;
      else                            pass_d[o] = pass_q[o];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      lockph_q <= '0;
      locked_q <= 1'b0;
      fail_q   <= '0;
      for (int o = 0; o < SLOTS; o++) pass_q[o] <= '0;
    end else begin
      phase_q  <= phase_d;
      locked_q <= locked_d;
      fail_q   <= fail_d;
      if (lockph_en) lockph_q <= lockph_d;
      for (int o = 0; o < SLOTS; o++) pass_q[o] <= pass_d[o];
    end
  end

  assign locked_o     = locked_q;
  assign frame_tick_o = tick;

  genvar g;
  for (g = 0; g < SLOTS; g++) begin : g_pass_chk
    // R3: a run never reaches the lock count without locking
    assert_pass_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pass_q[g] <= PASS_TOP);
    // R7: no stale search history survives while locked
    assert_search_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |-> (pass_q[g] == '0));
  end

  assert_fail_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q <= FAIL_TOP);

  assert_drop_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(tick && !all_ok_i));

  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rx3_frame_rx.sv
module rx3_frame_rx
  import rx3_pkg::*;
#(
  parameter int LOCK_FRAMES   = 4,
  parameter int UNLOCK_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  ser_i,
  output logic              frame_vld_o,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o,
  output logic [WORD_W-1:0] word_c_o,
  output logic [WORD_W-1:0] word_d_o,
  output logic [WORDS-1:0]  par_err_o,
  output logic              lock_o
);
  window_t          win;
  word_set_t        words, words_q, words_d;
  logic [WORDS-1:0] perr, perr_q, perr_d;
  logic             all_ok, tick, locked;
  logic             vld_q, vld_d;

  rx3_lane_shift i_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .ser_i (ser_i),
    .win_o (win)
  );

  rx3_frame_decode i_decode (
    .win_i    (win),
    .words_o  (words),
    .perr_o   (perr),
    .all_ok_o (all_ok)
  );

  rx3_align_ctrl #(
    .LOCK_FRAMES   (LOCK_FRAMES),
    .UNLOCK_FRAMES (UNLOCK_FRAMES)
  ) i_align (
    .clk          (clk),
    .rst_n        (rst_n),
    .all_ok_i     (all_ok),
    .locked_o     (locked),
    .frame_tick_o (tick)
  );

  always_comb begin
    vld_d   = tick;
    words_d = words;
    perr_d  = perr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      words_q <= '0;
      perr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (tick) begin
        words_q <= words_d;
        perr_q  <= perr_d;
      end
    end
  end

  assign frame_vld_o = vld_q;
  assign word_a_o    = words_q[0];
  assign word_b_o    = words_q[1];
  assign word_c_o    = words_q[2];
  assign word_d_o    = words_q[3];
  assign par_err_o   = perr_q;
  assign lock_o      = locked;

  assert_vld_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |-> $past(lock_o));

  assert_vld_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |=> !frame_vld_o);

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld_o |-> ($stable(words_q) && $stable(perr_q)));
endmodule

// File: tb/test_rx3_frame_rx.sv
module test_rx3_frame_rx;
  localparam int LOCKF   = 4;
  localparam int UNLOCKF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ser = 3'b000;
  logic       vld, lock;
  logic [7:0] wa, wb, wc, wd;
  logic [3:0] perr;

  int checks = 0;
  int errors = 0;
  int wdog = 0;

  always #2 clk = ~clk;

  rx3_frame_rx #(.LOCK_FRAMES(LOCKF), .UNLOCK_FRAMES(UNLOCKF)) i_rx3_frame_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_i       (ser),
    .frame_vld_o (vld),
    .word_a_o    (wa),
    .word_b_o    (wb),
    .word_c_o    (wc),
    .word_d_o    (wd),
    .par_err_o   (perr),
    .lock_o      (lock)
  );

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: per-cycle parity history, lock decided at stride 12
  bit         hist [3][12];
  bit         okq [$];
  int         cyc, start, m_ph, m_fail;
  bit         m_lock, e_vld, m_ok, m_can;
  logic [7:0] mw [4];
  logic [7:0] e_w [4];
  bit         mp [4];
  logic [3:0] merr, e_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 3; l++) for (int s = 0; s < 12; s++) hist[l][s] = 1'b0;
      okq.delete();
      cyc = 0; start = 0; m_ph = 0; m_fail = 0;
      m_lock = 1'b0; e_vld = 1'b0; e_err = 4'h0;
      for (int i = 0; i < 4; i++) e_w[i] = 8'h00;
    end else begin
      for (int k = 0; k < 8; k++) begin
        mw[0][k] = hist[0][k];
        mw[1][k] = hist[1][k];
        mw[2][k] = hist[2][k];
      end
      mp[0] = hist[0][8]; mp[1] = hist[1][8]; mp[2] = hist[2][8];
      mw[3] = {hist[2][10], hist[2][9], hist[1][11], hist[1][10], hist[1][9],
               hist[0][11], hist[0][10], hist[0][9]};
      mp[3] = hist[2][11];
      for (int i = 0; i < 4; i++) merr[i] = ((^{mp[i], mw[i]}) == 1'b0);
      m_ok = (merr == 4'h0);
      okq.push_back(m_ok);
      e_vld = 1'b0;
      if (!m_lock) begin
        m_can = (cyc - start >= 12 * (LOCKF - 1));
        if (m_can) for (int j = 0; j < LOCKF; j++) if (!okq[cyc - 12 * j]) m_can = 1'b0;
        if (m_can) begin
          m_lock = 1'b1; m_ph = cyc % 12; m_fail = 0;
        end
      end else if (cyc % 12 == m_ph) begin
        e_vld = 1'b1;
        for (int i = 0; i < 4; i++) e_w[i] = mw[i];
        e_err = merr;
        if (!m_ok) begin
          m_fail++;
          if (m_fail == UNLOCKF) begin
            m_lock = 1'b0; m_fail = 0; start = cyc + 1;
          end
        end else begin
          m_fail = 0;
        end
      end
      for (int l = 0; l < 3; l++) begin
        for (int s = 0; s < 11; s++) hist[l][s] = hist[l][s+1];
        hist[l][11] = ser[l];
      end
      cyc++;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(lock == m_lock, "R3/R6/R7 lock_o", lock, m_lock);
      chk(vld == e_vld, "R4 frame_vld_o", vld, e_vld);
      chk({wd, wc, wb, wa} == {e_w[3], e_w[2], e_w[1], e_w[0]}, "R1/R5 words",
          {wd, wc, wb, wa}, {e_w[3], e_w[2], e_w[1], e_w[0]});
      chk(perr == e_err, "R2 par_err_o", perr, e_err);
    end
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wdog, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic put(input logic [2:0] b);
    @(negedge clk);
    ser = b;
  endtask

  task automatic put_zeros(input int n);
    for (int i = 0; i < n; i++) put(3'b000);
  endtask

  // flip bit n inverts the parity of word n; want_lock >= 0 checks lock_o
  // after slot 1 of this frame (previous frame fully decided by then)
  task automatic send_frame(input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] c, input logic [7:0] d,
                            input logic [3:0] flip, input int want_lock,
                            input string tag);
    logic [8:0] fa, fb, fc, fd;
    fa = {(~^a) ^ flip[0], a};
    fb = {(~^b) ^ flip[1], b};
    fc = {(~^c) ^ flip[2], c};
    fd = {(~^d) ^ flip[3], d};
    for (int s = 0; s < 9; s++) begin
      put({fc[s], fb[s], fa[s]});
      if (s == 1 && want_lock >= 0) chk(lock == want_lock[0], tag, lock, want_lock);
    end
    put({fd[6], fd[3], fd[0]});
    put({fd[7], fd[4], fd[1]});
    put({fd[8], fd[5], fd[2]});
  endtask

  task automatic send_rand(input logic [3:0] flip, input int want_lock, input string tag);
    send_frame(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), flip, want_lock, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(lock == 1'b0, "R8 lock_o in reset", lock, 0);
    chk(vld == 1'b0, "R8 frame_vld_o in reset", vld, 0);
    chk({wd, wc, wb, wa} == 32'h0, "R8 words in reset", {wd, wc, wb, wa}, 0);
    chk(perr == 4'h0, "R8 par_err_o in reset", perr, 0);
    @(negedge clk);
    rst_n = 1'b1;

    put_zeros(5);
    // R3: three passing frames are not enough, the fourth locks
    send_rand(4'h0, -1, "");
    send_rand(4'h0, -1, "");
    send_rand(4'h0, -1, "");
    send_rand(4'h0, 0, "R3 not locked after 3 frames");
    send_rand(4'h0, 1, "R3 locked after 4 frames");

    // R1: directed data patterns
    send_frame(8'h00, 8'h00, 8'h00, 8'h00, 4'h0, 1, "R1 lock held");
    send_frame(8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'h0, -1, "");
    send_frame(8'h01, 8'h80, 8'h55, 8'hAA, 4'h0, -1, "");
    send_frame(8'h3C, 8'hC3, 8'h0F, 8'hE1, 4'h0, -1, "");

    // R6: failing runs broken by a passing frame keep lock
    send_rand(4'h8, -1, "");
    send_rand(4'h0, -1, "");
    send_rand(4'h1, -1, "");
    send_rand(4'h6, -1, "");
    send_rand(4'h0, 1, "R6 lock kept after two bad frames");
    send_rand(4'h0, 1, "R6 lock kept after reset of fail run");

    // R6: three consecutive bad frames drop lock
    send_rand(4'h2, -1, "");
    send_rand(4'h4, -1, "");
    send_rand(4'hF, -1, "");
    put_zeros(2);
    chk(lock == 1'b0, "R6 lock lost after 3 bad frames", lock, 0);

    // R7: fresh search at a new offset
    put_zeros(17);
    send_rand(4'h0, 0, "R7 unlocked in gap");
    send_rand(4'h0, -1, "");
    send_rand(4'h0, -1, "");
    send_rand(4'h0, 0, "R7 not locked after 3 fresh frames");
    send_rand(4'h0, 1, "R7 relocked after 4 fresh frames");

    for (int i = 0; i < 30; i++)
      send_rand((i % 7 == 3) ? 4'h4 : 4'h0, -1, "");

    // R8: reset in mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(lock == 1'b0, "R8 lock_o after mid reset", lock, 0);
    chk(vld == 1'b0, "R8 frame_vld_o after mid reset", vld, 0);
    chk({wd, wc, wb, wa} == 32'h0, "R8 words after mid reset", {wd, wc, wb, wa}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    put_zeros(3);
    send_rand(4'h0, -1, "");
    send_rand(4'h0, -1, "");
    send_rand(4'h0, -1, "");
    send_rand(4'h0, 0, "R8 search restarted after reset");
    send_rand(4'h0, 1, "R3 locked again after reset");
    send_rand(4'h0, -1, "");
    put_zeros(14);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule